// File: doc/BRIEF.md
# Event Time-Stamp Capture with Pulse-Per-Second Reference

This block time-stamps external events against a free-running cycle counter that runs from a 50 MHz clock. A once-per-second reference pulse and an external event input each latch the counter into their own register. The block reports each captured event to a processor through a flag, and it computes how far the event lies past the most recent reference pulse, in 10 ns units.

Each asynchronous input passes through a two-flop synchroniser and an edge detector. The event and fast-clear inputs each have their own edge-polarity select. After a capture, the block holds off further captures until the processor acknowledges the flag or a fast-clear edge discards the pending event. Events are refused while the receiver reports no valid position. The block also drives a 2 µs copy of the reference pulse and a longer stretched copy for an indicator lamp.

Top module: `evt_stamp_top`

## Requirements
- R1: After reset, `event_flag`, `overrun_flag`, `pps_out` and `pps_led` are 0, and `evt_stamp`, `pps_stamp` and `evt_offset` are 0.
- R2: An active event edge applied to `evt_in` sets `event_flag` on the fourth rising clock edge after the input changes, and not earlier.
- R3: `evt_edge_fall` = 0 selects the rising edge of `evt_in` and 1 selects the falling edge. A transition of the other polarity captures nothing.
- R4: Each reference leading edge (rising edge of `pps_in`) stores the counter in `pps_stamp`. Two successive stamps differ by the number of clock cycles between the two edges.
- R5: On capture, `evt_offset` = ((`evt_stamp` − `pps_stamp`) mod 2^32) × 2, truncated to its low 27 bits. This is the event's position within the second in 10 ns units.
- R6: While `event_flag` is 1, further event edges leave `evt_stamp` and `evt_offset` unchanged and set `overrun_flag`. A one-cycle `evt_ack` pulse clears both flags on the next clock edge, and the next event is then captured.
- R7: An active edge on `fclr_in` clears `event_flag` without touching `overrun_flag`. `fclr_edge_fall` selects its polarity (0 rising, 1 falling) independently of the event select, and the other polarity has no effect.
- R8: While `pos_valid` is 0 (fewer than three satellites), event edges set neither flag.
- R9: `pps_out` rises in the same cycle that `pps_stamp` is loaded and stays high for `PULSE_CYC` cycles (2 µs at 50 MHz by default).
- R10: `pps_led` rises with `pps_out` and stays high for `STRETCH_CYC` cycles (50 ms by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz counter clock |
| rst | input | 1 | Synchronous active-high reset |
| pps_in | input | 1 | Asynchronous once-per-second reference pulse |
| evt_in | input | 1 | Asynchronous external event input |
| fclr_in | input | 1 | Asynchronous fast-clear input |
| evt_edge_fall | input | 1 | Event polarity: 0 rising, 1 falling |
| fclr_edge_fall | input | 1 | Fast-clear polarity: 0 rising, 1 falling |
| pos_valid | input | 1 | 1 when the receiver tracks three or more satellites |
| evt_ack | input | 1 | Processor acknowledge; clears both flags |
| event_flag | output | 1 | A captured event awaits the processor |
| overrun_flag | output | 1 | An event edge arrived while a capture was pending |
| evt_stamp | output | CNT_W | Counter value latched at the event |
| pps_stamp | output | CNT_W | Counter value latched at the last reference edge |
| evt_offset | output | OFS_W | Event offset within the second, 10 ns units |
| pps_out | output | 1 | Regenerated reference pulse |
| pps_led | output | 1 | Stretched reference pulse for an indicator |

## Verification
Each input runs through three synchroniser and edge registers before the capture register. A flag, a stamp or the start of a pulse output therefore appears after the fourth rising edge that follows an input change. An `evt_ack` pulse takes effect on the next edge. The bench drives inputs just after a falling edge and samples on falling edges. It checks the latency exactly, with one sample taken one edge early, and takes the other results six edges after a stimulus, once they have settled. Offsets are checked as differences between two inputs whose latency is equal, so the absolute counter value never enters a check. Pulse widths are measured by counting high samples over a window longer than the pulse.

// File: rtl/evt_stamp_pkg.sv
package evt_stamp_pkg;
  typedef enum logic {
    POL_RISE = 1'b0,
    POL_FALL = 1'b1
  } edge_pol_e;

  function automatic logic pol_hit(input edge_pol_e pol, input logic now_v, input logic old_v);
    return (pol == POL_FALL) ? (old_v & ~now_v) : (now_v & ~old_v);
  endfunction
endpackage

// File: rtl/sync_edge.sv
module sync_edge
  import evt_stamp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic fall_sel,
  output logic edge_q
);
  localparam int SYNC_N = 3;
  logic [SYNC_N-1:0] sh;
  edge_pol_e pol;

  assign pol = fall_sel ? POL_FALL : POL_RISE;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      edge_q <= 1'b0;
    end else begin
      sh     <= {sh[SYNC_N-2:0], din};
      edge_q <= pol_hit(pol, sh[SYNC_N-2], sh[SYNC_N-1]);
    end
  end

  // R3: an edge pulse lasts a single cycle unless the polarity select moves
  a_r3_edge_single: assert property (@(posedge clk) disable iff (rst)
    (edge_q && $stable(fall_sel)) |=> (!edge_q || !$stable(fall_sel)));
endmodule

// File: rtl/pulse_stretch.sv
module pulse_stretch #(
  parameter int LEN = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic pulse_o
);
  localparam int CW = (LEN < 2) ? 1 : $clog2(LEN);
  localparam logic [CW-1:0] RELOAD = CW'(LEN - 1);
  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left    <= '0;
      pulse_o <= 1'b0;
    end else if (trig) begin
      left    <= RELOAD;
      pulse_o <= 1'b1;
    end else if (left != '0) begin
      left    <= left - 1'b1;
      pulse_o <= 1'b1;
    end else begin
      pulse_o <= 1'b0;
    end
  end

  // R9/R10: a pulse starts only because of a trigger
  a_r9_start_on_trig: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_o) |-> $past(trig));
endmodule

// File: rtl/stamp_core.sv
module stamp_core #(
  parameter int CNT_W = 32,
  parameter int OFS_W = 27
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pps_p,
  input  logic             evt_p,
  input  logic             fclr_p,
  input  logic             ack,
  input  logic             pos_valid,
  output logic             event_flag,
  output logic             overrun_flag,
  output logic [CNT_W-1:0] evt_stamp,
  output logic [CNT_W-1:0] pps_stamp,
  output logic [OFS_W-1:0] evt_offset
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] ref_now;
  logic [CNT_W-1:0] span;
  logic [CNT_W-1:0] span_x2;
  logic             take;
  logic             lost;

  assign ref_now = pps_p ? cnt : pps_stamp;
  assign span    = cnt - ref_now;
  assign span_x2 = span << 1;
  assign take    = evt_p && pos_valid && !event_flag && !fclr_p && !ack;
  assign lost    = evt_p && pos_valid && event_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt          <= '0;
      pps_stamp    <= '0;
      evt_stamp    <= '0;
      evt_offset   <= '0;
      event_flag   <= 1'b0;
      overrun_flag <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (pps_p) pps_stamp <= cnt;
      if (fclr_p || ack) begin
        event_flag <= 1'b0;
      end else if (take) begin
        event_flag <= 1'b1;
        evt_stamp  <= cnt;
        evt_offset <= span_x2[OFS_W-1:0];
      end
      if (ack) overrun_flag <= 1'b0;
      else if (lost) overrun_flag <= 1'b1;
    end
  end

  a_r6_holdoff_stable: assert property (@(posedge clk) disable iff (rst)
    (event_flag && !ack && !fclr_p) |=> ($stable(evt_stamp) && $stable(evt_offset)));
  a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    (overrun_flag && !ack) |=> overrun_flag);
  a_r7_fclr_clears: assert property (@(posedge clk) disable iff (rst)
    fclr_p |=> !event_flag);
  a_r8_no_capture_invalid: assert property (@(posedge clk) disable iff (rst)
    (!event_flag && !pos_valid) |=> !event_flag);
endmodule

// File: rtl/evt_stamp_top.sv
module evt_stamp_top #(
  parameter int CNT_W       = 32,
  parameter int OFS_W       = 27,
  parameter int PULSE_CYC   = 100,
  parameter int STRETCH_CYC = 2_500_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pps_in,
  input  logic             evt_in,
  input  logic             fclr_in,
  input  logic             evt_edge_fall,
  input  logic             fclr_edge_fall,
  input  logic             pos_valid,
  input  logic             evt_ack,
  output logic             event_flag,
  output logic             overrun_flag,
  output logic [CNT_W-1:0] evt_stamp,
  output logic [CNT_W-1:0] pps_stamp,
  output logic [OFS_W-1:0] evt_offset,
  output logic             pps_out,
  output logic             pps_led
);
  localparam int NIN = 3;
  logic [NIN-1:0] raw_in;
  logic [NIN-1:0] pol_in;
  logic [NIN-1:0] hit;

  assign raw_in = {fclr_in, evt_in, pps_in};
  assign pol_in = {fclr_edge_fall, evt_edge_fall, 1'b0};

  for (genvar i = 0; i < NIN; i++) begin : g_sync
    sync_edge u_sync (
      .clk     (clk),
      .rst     (rst),
      .din     (raw_in[i]),
      .fall_sel(pol_in[i]),
      .edge_q  (hit[i])
    );
  end

  stamp_core #(.CNT_W(CNT_W), .OFS_W(OFS_W)) u_core (
    .clk         (clk),
    .rst         (rst),
    .pps_p       (hit[0]),
    .evt_p       (hit[1]),
    .fclr_p      (hit[2]),
    .ack         (evt_ack),
    .pos_valid   (pos_valid),
    .event_flag  (event_flag),
    .overrun_flag(overrun_flag),
    .evt_stamp   (evt_stamp),
    .pps_stamp   (pps_stamp),
    .evt_offset  (evt_offset)
  );

  pulse_stretch #(.LEN(PULSE_CYC)) u_pps_pulse (
    .clk(clk), .rst(rst), .trig(hit[0]), .pulse_o(pps_out)
  );

  pulse_stretch #(.LEN(STRETCH_CYC)) u_pps_led (
    .clk(clk), .rst(rst), .trig(hit[0]), .pulse_o(pps_led)
  );
endmodule

// File: tb/tb_evt_stamp_top.sv
module tb_evt_stamp_top;
  localparam int CNT_W = 32;
  localparam int OFS_W = 27;
  localparam int PW    = 100;
  localparam int SW    = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pps_in = 0, evt_in = 0, fclr_in = 0;
  logic evt_edge_fall = 0, fclr_edge_fall = 0, pos_valid = 1, evt_ack = 0;
  logic event_flag, overrun_flag, pps_out, pps_led;
  logic [CNT_W-1:0] evt_stamp, pps_stamp;
  logic [OFS_W-1:0] evt_offset;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  evt_stamp_top #(.CNT_W(CNT_W), .OFS_W(OFS_W), .PULSE_CYC(PW), .STRETCH_CYC(SW)) dut (
    .clk(clk), .rst(rst), .pps_in(pps_in), .evt_in(evt_in), .fclr_in(fclr_in),
    .evt_edge_fall(evt_edge_fall), .fclr_edge_fall(fclr_edge_fall),
    .pos_valid(pos_valid), .evt_ack(evt_ack), .event_flag(event_flag),
    .overrun_flag(overrun_flag), .evt_stamp(evt_stamp), .pps_stamp(pps_stamp),
    .evt_offset(evt_offset), .pps_out(pps_out), .pps_led(pps_led)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_ack();
    @(negedge clk); evt_ack = 1'b1;
    @(negedge clk); evt_ack = 1'b0;
  endtask

  task automatic evt_rise_fall();
    @(negedge clk); evt_in = 1'b1; wait_n(6);
    evt_in = 1'b0; wait_n(6);
  endtask

  task automatic t_reset();
    check("R1 event_flag", event_flag, 0);
    check("R1 overrun_flag", overrun_flag, 0);
    check("R1 pps_out", pps_out, 0);
    check("R1 pps_led", pps_led, 0);
    check("R1 evt_stamp", evt_stamp, 0);
    check("R1 pps_stamp", pps_stamp, 0);
    check("R1 evt_offset", evt_offset, 0);
  endtask

  task automatic t_latency();
    @(negedge clk); evt_in = 1'b1;
    wait_n(3);
    check("R2 flag not yet", event_flag, 0);
    wait_n(1);
    check("R2 flag on 4th edge", event_flag, 1);
    evt_in = 1'b0; wait_n(6);
    do_ack();
    check("R6 ack clears flag", event_flag, 0);
  endtask

  task automatic t_offset(input int d);
    @(negedge clk); pps_in = 1'b1;
    wait_n(d);
    evt_in = 1'b1;
    wait_n(6);
    check("R5 offset", evt_offset, (2 * d) & ((1 << OFS_W) - 1));
    check("R5 stamp diff", evt_stamp - pps_stamp, d);
    pps_in = 1'b0; evt_in = 1'b0;
    wait_n(6);
    do_ack();
    wait_n(SW + 10);
  endtask

  task automatic t_pps_period(input int p);
    logic [CNT_W-1:0] s1;
    @(negedge clk); pps_in = 1'b1;
    wait_n(6); s1 = pps_stamp;
    wait_n(4); pps_in = 1'b0;
    wait_n(p - 10); pps_in = 1'b1;
    wait_n(6);
    check("R4 pps period", pps_stamp - s1, p);
    pps_in = 1'b0;
    wait_n(SW + 10);
  endtask

  task automatic t_pps_width();
    int hi_o = 0;
    int hi_l = 0;
    @(negedge clk); pps_in = 1'b1;
    wait_n(3);
    check("R9 pps_out not yet", pps_out, 0);
    for (int i = 0; i < SW + 50; i++) begin
      @(negedge clk);
      if (i == 0) check("R9 pps_out rises with stamp", pps_out, 1);
      if (i == 10) pps_in = 1'b0;
      if (pps_out) hi_o++;
      if (pps_led) hi_l++;
    end
    check("R9 pps_out width", hi_o, PW);
    check("R10 pps_led width", hi_l, SW);
  endtask

  task automatic t_holdoff();
    logic [CNT_W-1:0] st;
    logic [OFS_W-1:0] of;
    evt_rise_fall();
    check("R6 first capture", event_flag, 1);
    check("R6 no overrun yet", overrun_flag, 0);
    st = evt_stamp; of = evt_offset;
    evt_rise_fall();
    check("R6 stamp held", evt_stamp, st);
    check("R6 offset held", evt_offset, of);
    check("R6 overrun set", overrun_flag, 1);
    do_ack();
    check("R6 ack clears overrun", overrun_flag, 0);
    evt_rise_fall();
    check("R6 recapture after ack", event_flag, 1);
    check("R6 new stamp", evt_stamp != st, 1);
    do_ack();
  endtask

  task automatic t_fall_edge();
    @(negedge clk); evt_edge_fall = 1'b1;
    @(negedge clk); evt_in = 1'b1; wait_n(6);
    check("R3 rising ignored when falling selected", event_flag, 0);
    evt_in = 1'b0; wait_n(6);
    check("R3 falling edge captures", event_flag, 1);
    do_ack();
    evt_edge_fall = 1'b0;
    wait_n(4);
  endtask

  task automatic t_fclr();
    evt_rise_fall();
    check("R7 pending before clear", event_flag, 1);
    @(negedge clk); fclr_in = 1'b1; wait_n(6);
    check("R7 rising clear", event_flag, 0);
    fclr_in = 1'b0; wait_n(6);
    fclr_edge_fall = 1'b1; wait_n(2);
    evt_rise_fall();
    evt_rise_fall();
    check("R7 overrun untouched by clear", overrun_flag, 1);
    @(negedge clk); fclr_in = 1'b1; wait_n(6);
    check("R7 rising ignored when falling selected", event_flag, 1);
    fclr_in = 1'b0; wait_n(6);
    check("R7 falling clear", event_flag, 0);
    check("R7 overrun kept", overrun_flag, 1);
    evt_rise_fall();
    check("R7 ready for next event", event_flag, 1);
    do_ack();
    fclr_edge_fall = 1'b0;
    wait_n(4);
  endtask

  task automatic t_posvalid();
    @(negedge clk); pos_valid = 1'b0;
    evt_rise_fall();
    check("R8 no capture without position", event_flag, 0);
    check("R8 no overrun without position", overrun_flag, 0);
    pos_valid = 1'b1;
    evt_rise_fall();
    check("R8 capture once valid", event_flag, 1);
    do_ack();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    wait_n(5);
    @(negedge clk); rst = 1'b0;
    wait_n(2);
    t_reset();
    t_latency();
    t_offset(0);
    t_offset(37);
    t_offset(1000);
    t_pps_period(500);
    t_pps_width();
    t_holdoff();
    t_fall_edge();
    t_fclr();
    t_posvalid();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule